// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement Control

This block keeps the program-order window of an out-of-order core. Every cycle it writes a bundle of renamed instructions into the tail of a circular buffer. It retires ready entries from the head, strictly in program order and up to a fixed bandwidth. It also applies completion marks that the execute stage sends by slot tag. The tag of an instruction is the buffer slot that it was written into. Upstream learns that slot from the allocation pointer output, because kept lanes take consecutive slots starting there.

Three head conditions stop retirement. A head entry that is held for non-speculative execution is handed back to execute by its sequence number. A faulting entry is reported by its PC. A head entry that is not ready simply waits. A squash request from execute switches the block into a walk state. In that state it removes the youngest entries over several cycles, reports its progress and accepts no new work. Every output is registered, so each output shows the result of the cycle before.

Top module: `rob_commit_ctrl`

## Requirements
- R1: After reset the buffer is empty: free count equals DEPTH, allocation pointer is 0, and every pulse output and the squash-in-progress flag are low.
- R2: In a running cycle with no squash arriving, input lanes are considered in lane order from lane 0. Each valid lane whose drop bit is clear is written at the next tail slot. A lane with its drop bit set, or one that arrives when the buffer is full, is discarded. Free count = DEPTH minus occupancy, and it is visible on the next cycle.
- R3: Up to CMT_W entries leave from the head per cycle, in order, stopping at the first entry that is not ready. The following cycle shows the committed count, a commit pulse, and the sequence number of the last committed entry.
- R4: Completion marks are applied after the retirement step of the same cycle. An entry completed in cycle N is retired no earlier than cycle N+1.
- R5: A completion with the kill bit set marks its entry squashed and ready. A squashed head entry leaves the buffer and uses one retirement slot. It is not counted as committed and does not update the reported sequence number.
- R6: A non-speculative entry is written already ready but not executed. When such an entry reaches the head, the block pulses an execute request carrying its sequence number, clears its ready flag and stops retiring. There is no further request for it; it retires after a completion arrives.
- R7: A head entry that retires with its fault bit set is committed and raises a one-cycle fault pulse with its PC. No later entry retires in that cycle.
- R8: A squash request in a running cycle enters the walk state. The next cycle shows the squash pulse, the squash-in-progress flag, the request's sequence number and the forwarded mispredict, taken, corrected-PC and mispredicted-PC values. Nothing is inserted or retired in that cycle.
- R9: Each walk cycle removes up to WALK_W entries from the tail whose sequence number is greater than the squash number (unsigned compare). The walk cycle reports squash-in-progress and the sequence number of the youngest remaining entry.
- R10: The first walk cycle that finds nothing to remove returns the block to running with squash-in-progress low. That cycle neither inserts nor retires.
- R11: During the walk, both squash requests and input lanes are ignored.
- R12: A completion whose tag names an empty slot has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | IN_W | Lane carries an instruction |
| in_drop_i | input | IN_W | Lane instruction already squashed, discard |
| in_nonspec_i | input | IN_W | Lane instruction must execute non-speculatively |
| in_fault_i | input | IN_W | Lane instruction carries a fault |
| in_seq_i | input | IN_W x SEQ_W | Lane sequence numbers |
| in_pc_i | input | IN_W x PC_W | Lane PCs |
| cpl_valid_i | input | CPL_W | Completion port active |
| cpl_kill_i | input | CPL_W | Completion marks the entry squashed |
| cpl_tag_i | input | CPL_W x log2(DEPTH) | Slot tag of the completed entry |
| sq_valid_i | input | 1 | Squash request from execute |
| sq_seq_i | input | SEQ_W | Youngest surviving sequence number |
| sq_mispred_i | input | 1 | Squash caused by a mispredict |
| sq_taken_i | input | 1 | Resolved branch direction |
| sq_next_pc_i | input | PC_W | Corrected fetch PC |
| sq_bad_pc_i | input | PC_W | PC of the mispredicted branch |
| alloc_ptr_o | output | log2(DEPTH) | Slot that the next kept lane will use |
| free_o | output | log2(DEPTH)+1 | Free entries |
| cmt_valid_o | output | 1 | At least one entry committed |
| cmt_cnt_o | output | log2(CMT_W+1) | Entries committed |
| cmt_seq_o | output | SEQ_W | Sequence number of last committed entry |
| ns_valid_o | output | 1 | Non-speculative execute request |
| ns_seq_o | output | SEQ_W | Sequence number to execute |
| flt_valid_o | output | 1 | Faulting entry committed |
| flt_pc_o | output | PC_W | PC of the faulting entry |
| sq_flag_o | output | 1 | Squash accepted this cycle |
| squashing_o | output | 1 | Walk in progress |
| sq_seq_o | output | SEQ_W | Squash number, then youngest remaining sequence |
| sq_mispred_o | output | 1 | Forwarded mispredict flag |
| sq_taken_o | output | 1 | Forwarded taken flag |
| sq_next_pc_o | output | PC_W | Forwarded corrected PC |
| sq_bad_pc_o | output | PC_W | Forwarded mispredicted PC |

## Verification
A corrupted head pointer or occupancy count shows up one cycle later, either as a wrong free count or as a committed sequence number out of program order. A ready flag set or cleared on the wrong slot shows up as a premature commit, a repeated execute request, or a commit that never comes. A wrong tail or walk compare shows up within a few cycles: the walk runs for the wrong number of cycles, reports the wrong youngest sequence number, or leaves the wrong free count and allocation pointer when it ends.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int SEQ_W = 8;
    localparam int PC_W  = 16;

    typedef struct packed {
        logic             valid;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  pc;
        logic             executed;
        logic             ready;
        logic             squashed;
        logic             nonspec;
        logic             fault;
    } rob_entry_t;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_WALK = 1'b1
    } rob_mode_e;

endpackage

// File: rtl/rob_retire_scan.sv
// Decides, from the registered buffer, how many head entries leave this cycle.
module rob_retire_scan
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CMT_W = 2,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1,
    localparam int NW = $clog2(CMT_W + 1)
) (
    input  rob_entry_t [DEPTH-1:0] ents_i,
    input  logic [AW-1:0]          head_i,
    input  logic [CW-1:0]          count_i,
    output logic [NW-1:0]          pop_o,
    output logic [NW-1:0]          cmt_o,
    output logic [SEQ_W-1:0]       last_seq_o,
    output logic                   ns_o,
    output logic [AW-1:0]          ns_idx_o,
    output logic [SEQ_W-1:0]       ns_seq_o,
    output logic                   flt_o,
    output logic [PC_W-1:0]        flt_pc_o
);

    logic          go;
    logic [AW-1:0] idx;
    rob_entry_t    e;

    always_comb begin
        pop_o      = '0;
        cmt_o      = '0;
        last_seq_o = '0;
        ns_o       = 1'b0;
        ns_idx_o   = '0;
        ns_seq_o   = '0;
        flt_o      = 1'b0;
        flt_pc_o   = '0;
        go         = 1'b1;
        idx        = '0;
        e          = '0;
        for (int k = 0; k < CMT_W; k++) begin
            idx = head_i + AW'(k);
            e   = ents_i[idx];
            if (go && (k < int'(count_i)) && e.valid && e.ready) begin
                if (e.squashed) begin
                    pop_o = pop_o + NW'(1);
                end else if (!e.executed) begin
                    if (e.nonspec) begin
                        ns_o     = 1'b1;
                        ns_idx_o = idx;
                        ns_seq_o = e.seq;
                    end
                    go = 1'b0;
                end else begin
                    pop_o      = pop_o + NW'(1);
                    cmt_o      = cmt_o + NW'(1);
                    last_seq_o = e.seq;
                    if (e.fault) begin
                        flt_o    = 1'b1;
                        flt_pc_o = e.pc;
                        go       = 1'b0;
                    end
                end
            end else begin
                go = 1'b0;
            end
        end
    end

endmodule

// File: rtl/rob_walk_scan.sv
// Counts how many youngest entries the squash walk may remove this cycle.
module rob_walk_scan
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int WALK_W = 2,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1,
    localparam int RW = $clog2(WALK_W + 1)
) (
    input  logic [DEPTH-1:0]            valid_i,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
    input  logic [AW-1:0]               tail_i,
    input  logic [CW-1:0]               count_i,
    input  logic [SEQ_W-1:0]            target_i,
    output logic [RW-1:0]               n_o,
    output logic                        done_o
);

    logic          go;
    logic [AW-1:0] idx;

    always_comb begin
        n_o = '0;
        go  = 1'b1;
        idx = '0;
        for (int k = 0; k < WALK_W; k++) begin
            idx = tail_i - AW'(k + 1);
            if (go && (k < int'(count_i)) && valid_i[idx] && (seq_i[idx] > target_i)) begin
                n_o = n_o + RW'(1);
            end else begin
                go = 1'b0;
            end
        end
        done_o = (n_o == '0);
    end

endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int IN_W   = 2,
    parameter int CMT_W  = 2,
    parameter int WALK_W = 2,
    parameter int CPL_W  = 2
) (
    input  logic                                     clk_i,
    input  logic                                     rst_ni,
    input  logic [IN_W-1:0]                          in_valid_i,
    input  logic [IN_W-1:0]                          in_drop_i,
    input  logic [IN_W-1:0]                          in_nonspec_i,
    input  logic [IN_W-1:0]                          in_fault_i,
    input  logic [IN_W-1:0][SEQ_W-1:0]               in_seq_i,
    input  logic [IN_W-1:0][PC_W-1:0]                in_pc_i,
    input  logic [CPL_W-1:0]                         cpl_valid_i,
    input  logic [CPL_W-1:0]                         cpl_kill_i,
    input  logic [CPL_W-1:0][$clog2(DEPTH)-1:0]      cpl_tag_i,
    input  logic                                     sq_valid_i,
    input  logic [SEQ_W-1:0]                         sq_seq_i,
    input  logic                                     sq_mispred_i,
    input  logic                                     sq_taken_i,
    input  logic [PC_W-1:0]                          sq_next_pc_i,
    input  logic [PC_W-1:0]                          sq_bad_pc_i,
    output logic [$clog2(DEPTH)-1:0]                 alloc_ptr_o,
    output logic [$clog2(DEPTH):0]                   free_o,
    output logic                                     cmt_valid_o,
    output logic [$clog2(CMT_W+1)-1:0]               cmt_cnt_o,
    output logic [SEQ_W-1:0]                         cmt_seq_o,
    output logic                                     ns_valid_o,
    output logic [SEQ_W-1:0]                         ns_seq_o,
    output logic                                     flt_valid_o,
    output logic [PC_W-1:0]                          flt_pc_o,
    output logic                                     sq_flag_o,
    output logic                                     squashing_o,
    output logic [SEQ_W-1:0]                         sq_seq_o,
    output logic                                     sq_mispred_o,
    output logic                                     sq_taken_o,
    output logic [PC_W-1:0]                          sq_next_pc_o,
    output logic [PC_W-1:0]                          sq_bad_pc_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam int NW = $clog2(CMT_W + 1);
    localparam int RW = $clog2(WALK_W + 1);

    typedef struct packed {
        rob_entry_t [DEPTH-1:0] ents;
        logic [AW-1:0]          head;
        logic [AW-1:0]          tail;
        logic [CW-1:0]          count;
        rob_mode_e              mode;
        logic [SEQ_W-1:0]       target;
        logic                   cmt_valid;
        logic [NW-1:0]          cmt_cnt;
        logic [SEQ_W-1:0]       cmt_seq;
        logic                   ns_valid;
        logic [SEQ_W-1:0]       ns_seq;
        logic                   flt_valid;
        logic [PC_W-1:0]        flt_pc;
        logic                   sq_flag;
        logic                   squashing;
        logic [SEQ_W-1:0]       sq_seq;
        logic                   sq_mispred;
        logic                   sq_taken;
        logic [PC_W-1:0]        sq_next_pc;
        logic [PC_W-1:0]        sq_bad_pc;
    } state_t;

    state_t q, d;

    // Flat views of the registered buffer for the walk scan.
    logic [DEPTH-1:0]            ent_valid;
    logic [DEPTH-1:0][SEQ_W-1:0] ent_seq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_view
        assign ent_valid[g] = q.ents[g].valid;
        assign ent_seq[g]   = q.ents[g].seq;
    end

    logic [NW-1:0]    ret_pop;
    logic [NW-1:0]    ret_cmt;
    logic [SEQ_W-1:0] ret_seq;
    logic             ret_ns;
    logic [AW-1:0]    ret_ns_idx;
    logic [SEQ_W-1:0] ret_ns_seq;
    logic             ret_flt;
    logic [PC_W-1:0]  ret_flt_pc;
    logic [RW-1:0]    walk_n;
    logic             walk_done;

    rob_retire_scan #(
        .DEPTH (DEPTH),
        .CMT_W (CMT_W)
    ) u_retire (
        .ents_i     (q.ents),
        .head_i     (q.head),
        .count_i    (q.count),
        .pop_o      (ret_pop),
        .cmt_o      (ret_cmt),
        .last_seq_o (ret_seq),
        .ns_o       (ret_ns),
        .ns_idx_o   (ret_ns_idx),
        .ns_seq_o   (ret_ns_seq),
        .flt_o      (ret_flt),
        .flt_pc_o   (ret_flt_pc)
    );

    rob_walk_scan #(
        .DEPTH  (DEPTH),
        .WALK_W (WALK_W)
    ) u_walk (
        .valid_i  (ent_valid),
        .seq_i    (ent_seq),
        .tail_i   (q.tail),
        .count_i  (q.count),
        .target_i (q.target),
        .n_o      (walk_n),
        .done_o   (walk_done)
    );

    always_comb begin
        d            = q;
        d.cmt_valid  = 1'b0;
        d.cmt_cnt    = '0;
        d.ns_valid   = 1'b0;
        d.ns_seq     = '0;
        d.flt_valid  = 1'b0;
        d.flt_pc     = '0;
        d.sq_flag    = 1'b0;
        d.squashing  = 1'b0;
        d.sq_mispred = 1'b0;
        d.sq_taken   = 1'b0;
        d.sq_next_pc = '0;
        d.sq_bad_pc  = '0;

        if ((q.mode == MODE_RUN) && sq_valid_i) begin
            // Squash arrives: no insertion, no retirement this cycle.
            d.mode       = MODE_WALK;
            d.target     = sq_seq_i;
            d.sq_flag    = 1'b1;
            d.squashing  = 1'b1;
            d.sq_seq     = sq_seq_i;
            d.sq_mispred = sq_mispred_i;
            d.sq_taken   = sq_taken_i;
            d.sq_next_pc = sq_next_pc_i;
            d.sq_bad_pc  = sq_bad_pc_i;
        end else if (q.mode == MODE_WALK) begin
            if (walk_done) begin
                d.mode = MODE_RUN;
            end else begin
                for (int k = 0; k < WALK_W; k++) begin
                    if (k < int'(walk_n)) begin
                        d.ents[q.tail - AW'(k + 1)].valid = 1'b0;
                    end
                end
                d.tail      = q.tail - AW'(walk_n);
                d.count     = q.count - CW'(walk_n);
                d.squashing = 1'b1;
                d.sq_seq    = (q.count > CW'(walk_n))
                              ? q.ents[q.tail - AW'(walk_n) - AW'(1)].seq
                              : q.target;
            end
        end else begin
            // Retirement from the head.
            for (int k = 0; k < CMT_W; k++) begin
                if (k < int'(ret_pop)) begin
                    d.ents[q.head + AW'(k)].valid = 1'b0;
                end
            end
            d.head  = q.head + AW'(ret_pop);
            d.count = q.count - CW'(ret_pop);
            if (ret_ns) begin
                d.ents[ret_ns_idx].ready = 1'b0;
                d.ns_valid               = 1'b1;
                d.ns_seq                 = ret_ns_seq;
            end
            if (ret_cmt != '0) begin
                d.cmt_valid = 1'b1;
                d.cmt_cnt   = ret_cmt;
                d.cmt_seq   = ret_seq;
            end
            d.flt_valid = ret_flt;
            d.flt_pc    = ret_flt_pc;

            // Insertion at the tail, lane order.
            for (int l = 0; l < IN_W; l++) begin
                if (in_valid_i[l] && !in_drop_i[l] && (d.count < CW'(DEPTH))) begin
                    d.ents[d.tail] = '{valid:    1'b1,
                                       seq:      in_seq_i[l],
                                       pc:       in_pc_i[l],
                                       executed: 1'b0,
                                       ready:    in_nonspec_i[l],
                                       squashed: 1'b0,
                                       nonspec:  in_nonspec_i[l],
                                       fault:    in_fault_i[l]};
                    d.tail  = d.tail + AW'(1);
                    d.count = d.count + CW'(1);
                end
            end
        end

        // Completion marks come after retirement; only live, unchanged slots.
        for (int c = 0; c < CPL_W; c++) begin
            if (cpl_valid_i[c] && q.ents[cpl_tag_i[c]].valid && d.ents[cpl_tag_i[c]].valid
                && (d.ents[cpl_tag_i[c]].seq == q.ents[cpl_tag_i[c]].seq)) begin
                d.ents[cpl_tag_i[c]].ready = 1'b1;
                if (cpl_kill_i[c]) begin
                    d.ents[cpl_tag_i[c]].squashed = 1'b1;
                end else begin
                    d.ents[cpl_tag_i[c]].executed = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign alloc_ptr_o  = q.tail;
    assign free_o       = CW'(DEPTH) - q.count;
    assign cmt_valid_o  = q.cmt_valid;
    assign cmt_cnt_o    = q.cmt_cnt;
    assign cmt_seq_o    = q.cmt_seq;
    assign ns_valid_o   = q.ns_valid;
    assign ns_seq_o     = q.ns_seq;
    assign flt_valid_o  = q.flt_valid;
    assign flt_pc_o     = q.flt_pc;
    assign sq_flag_o    = q.sq_flag;
    assign squashing_o  = q.squashing;
    assign sq_seq_o     = q.sq_seq;
    assign sq_mispred_o = q.sq_mispred;
    assign sq_taken_o   = q.sq_taken;
    assign sq_next_pc_o = q.sq_next_pc;
    assign sq_bad_pc_o  = q.sq_bad_pc;

endmodule

// File: rtl/rob_commit_chk.sv
module rob_commit_chk #(
    parameter int DEPTH = 8,
    parameter int CMT_W = 2,
    localparam int CW = $clog2(DEPTH) + 1,
    localparam int NW = $clog2(CMT_W + 1)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [CW-1:0] free_o,
    input logic          cmt_valid_o,
    input logic [NW-1:0] cmt_cnt_o,
    input logic          ns_valid_o,
    input logic          flt_valid_o,
    input logic          sq_flag_o,
    input logic          squashing_o
);

    assert_free_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        free_o <= CW'(DEPTH));

    assert_cmt_bw_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmt_valid_o |-> (cmt_cnt_o != '0) && (cmt_cnt_o <= NW'(CMT_W)));

    assert_cmt_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmt_valid_o |-> (cmt_cnt_o == '0));

    assert_ns_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ns_valid_o |=> !ns_valid_o);

    assert_ns_no_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ns_valid_o |-> !flt_valid_o);

    assert_fault_commits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flt_valid_o |-> cmt_valid_o);

    assert_sq_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sq_flag_o |-> squashing_o && (free_o == $past(free_o)));

    assert_walk_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        squashing_o |-> !cmt_valid_o && !ns_valid_o && !flt_valid_o);

    assert_walk_frees_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (squashing_o && !sq_flag_o) |-> (free_o > $past(free_o)));

    assert_sq_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sq_flag_o |=> !sq_flag_o);

endmodule

bind rob_commit_ctrl rob_commit_chk #(
    .DEPTH (DEPTH),
    .CMT_W (CMT_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .free_o      (free_o),
    .cmt_valid_o (cmt_valid_o),
    .cmt_cnt_o   (cmt_cnt_o),
    .ns_valid_o  (ns_valid_o),
    .flt_valid_o (flt_valid_o),
    .sq_flag_o   (sq_flag_o),
    .squashing_o (squashing_o)
);

// File: tb/rob_commit_ctrl_tb_top.sv
module rob_commit_ctrl_tb_top;
    import rob_pkg::*;

    localparam int DEPTH = 8;
    localparam int IN_W  = 2;
    localparam int CPL_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [IN_W-1:0]             in_valid, in_drop, in_nonspec, in_fault;
    logic [IN_W-1:0][SEQ_W-1:0]  in_seq;
    logic [IN_W-1:0][PC_W-1:0]   in_pc;
    logic [CPL_W-1:0]            cpl_valid, cpl_kill;
    logic [CPL_W-1:0][2:0]       cpl_tag;
    logic                        sq_valid, sq_mispred, sq_taken;
    logic [SEQ_W-1:0]            sq_seq;
    logic [PC_W-1:0]             sq_next_pc, sq_bad_pc;
    logic [2:0]                  alloc_ptr;
    logic [3:0]                  free;
    logic                        cmt_valid, ns_valid, flt_valid, sq_flag, squashing;
    logic [1:0]                  cmt_cnt;
    logic [SEQ_W-1:0]            cmt_seq, ns_seq, sq_seq_out;
    logic [PC_W-1:0]             flt_pc, sq_next_pc_out, sq_bad_pc_out;
    logic                        sq_mispred_out, sq_taken_out;

    rob_commit_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .in_valid_i(in_valid), .in_drop_i(in_drop), .in_nonspec_i(in_nonspec),
        .in_fault_i(in_fault), .in_seq_i(in_seq), .in_pc_i(in_pc),
        .cpl_valid_i(cpl_valid), .cpl_kill_i(cpl_kill), .cpl_tag_i(cpl_tag),
        .sq_valid_i(sq_valid), .sq_seq_i(sq_seq), .sq_mispred_i(sq_mispred),
        .sq_taken_i(sq_taken), .sq_next_pc_i(sq_next_pc), .sq_bad_pc_i(sq_bad_pc),
        .alloc_ptr_o(alloc_ptr), .free_o(free), .cmt_valid_o(cmt_valid),
        .cmt_cnt_o(cmt_cnt), .cmt_seq_o(cmt_seq), .ns_valid_o(ns_valid),
        .ns_seq_o(ns_seq), .flt_valid_o(flt_valid), .flt_pc_o(flt_pc),
        .sq_flag_o(sq_flag), .squashing_o(squashing), .sq_seq_o(sq_seq_out),
        .sq_mispred_o(sq_mispred_out), .sq_taken_o(sq_taken_out),
        .sq_next_pc_o(sq_next_pc_out), .sq_bad_pc_o(sq_bad_pc_out)
    );

    int errs = 0;
    int checks = 0;
    int tot = 0;
    int ccyc = 0;
    int last = 0;

    task automatic eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errs, checks);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (cmt_valid) begin
            tot  += int'(cmt_cnt);
            ccyc += 1;
            last = int'(cmt_seq);
        end
    endtask

    task automatic idle_in();
        in_valid = '0; in_drop = '0; in_nonspec = '0; in_fault = '0;
        in_seq = '0; in_pc = '0;
        cpl_valid = '0; cpl_kill = '0; cpl_tag = '0;
        sq_valid = 1'b0; sq_seq = '0; sq_mispred = 1'b0; sq_taken = 1'b0;
        sq_next_pc = '0; sq_bad_pc = '0;
    endtask

    task automatic do_reset();
        idle_in();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        tot = 0; ccyc = 0; last = 0;
    endtask

    task automatic lane(input int l, input int seq, input bit ns, input bit flt, input bit drop);
        in_valid[l]   = 1'b1;
        in_seq[l]     = SEQ_W'(seq);
        in_pc[l]      = PC_W'(seq * 4);
        in_nonspec[l] = ns;
        in_fault[l]   = flt;
        in_drop[l]    = drop;
    endtask

    task automatic fill(input int n, input int seq0);
        for (int i = 0; i < n; i += 2) begin
            lane(0, seq0 + i, 1'b0, 1'b0, 1'b0);
            if (i + 1 < n) lane(1, seq0 + i + 1, 1'b0, 1'b0, 1'b0);
            step();
            idle_in();
        end
    endtask

    task automatic cpl(input int p, input int tag, input bit kill);
        cpl_valid[p] = 1'b1;
        cpl_tag[p]   = 3'(tag);
        cpl_kill[p]  = kill;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        eq("R1 free", int'(free), 8);
        eq("R1 alloc", int'(alloc_ptr), 0);
        eq("R1 pulses", int'({cmt_valid, ns_valid, flt_valid, sq_flag, squashing}), 0);

        // R2/R3: fill and drain sweep over every occupancy
        for (int n = 1; n <= DEPTH; n++) begin
            do_reset();
            fill(n, 10);
            eq("R2 free after fill", int'(free), 8 - n);
            eq("R2 alloc after fill", int'(alloc_ptr), n % 8);
            tot = 0; ccyc = 0;
            for (int i = 0; i < n; i += 2) begin
                cpl(0, i, 1'b0);
                if (i + 1 < n) cpl(1, i + 1, 1'b0);
                step();
                idle_in();
            end
            repeat (3) step();
            eq("R3 total committed", tot, n);
            eq("R3 commit cycles", ccyc, (n + 1) / 2);
            eq("R3 last seq", last, 10 + n - 1);
            eq("R3 free drained", int'(free), 8);
        end

        // R4: completion not visible to retirement in the same cycle
        do_reset();
        fill(2, 30);
        cpl(0, 0, 1'b0);
        step();
        idle_in();
        eq("R4 no same-cycle retire", int'(cmt_valid), 0);
        step();
        eq("R4 retire next cycle", int'(cmt_cnt), 1);
        eq("R4 seq", int'(cmt_seq), 30);

        // R3: retirement blocked by an unready head
        do_reset();
        fill(4, 40);
        cpl(0, 1, 1'b0); cpl(1, 2, 1'b0);
        step(); idle_in();
        cpl(0, 3, 1'b0);
        step(); idle_in();
        tot = 0;
        step();
        eq("R3 head blocks", tot, 0);
        cpl(0, 0, 1'b0);
        step(); idle_in();
        eq("R3 head blocks same cycle", int'(cmt_valid), 0);
        step();
        eq("R3 width cnt", int'(cmt_cnt), 2);
        eq("R3 width seq", int'(cmt_seq), 41);
        step();
        eq("R3 second pair seq", int'(cmt_seq), 43);

        // R5: killed head retires uncounted
        do_reset();
        fill(3, 20);
        cpl(0, 0, 1'b1); cpl(1, 1, 1'b0);
        step(); idle_in();
        cpl(0, 2, 1'b0);
        step(); idle_in();
        eq("R5 count skips killed", int'(cmt_cnt), 1);
        eq("R5 seq", int'(cmt_seq), 21);
        eq("R5 killed freed", int'(free), 7);
        step();
        eq("R5 next seq", int'(cmt_seq), 22);
        eq("R5 free", int'(free), 8);

        // R6: non-speculative head handed back
        do_reset();
        lane(0, 50, 1'b1, 1'b0, 1'b0);
        lane(1, 51, 1'b0, 1'b0, 1'b0);
        step(); idle_in();
        cpl(0, 1, 1'b0);
        step(); idle_in();
        eq("R6 request", int'(ns_valid), 1);
        eq("R6 request seq", int'(ns_seq), 50);
        eq("R6 no commit", int'(cmt_valid), 0);
        step();
        eq("R6 no retry", int'(ns_valid), 0);
        eq("R6 still blocked", int'(cmt_valid), 0);
        cpl(0, 0, 1'b0);
        step(); idle_in();
        step();
        eq("R6 retire after completion", int'(cmt_cnt), 2);
        eq("R6 last seq", int'(cmt_seq), 51);

        // R7: fault stops further retirement
        do_reset();
        lane(0, 60, 1'b0, 1'b1, 1'b0);
        lane(1, 61, 1'b0, 1'b0, 1'b0);
        step(); idle_in();
        lane(0, 62, 1'b0, 1'b0, 1'b0);
        step(); idle_in();
        cpl(0, 0, 1'b0); cpl(1, 1, 1'b0);
        step(); idle_in();
        cpl(0, 2, 1'b0);
        step(); idle_in();
        eq("R7 fault pulse", int'(flt_valid), 1);
        eq("R7 fault pc", int'(flt_pc), 240);
        eq("R7 stop after fault", int'(cmt_cnt), 1);
        step();
        eq("R7 pulse ends", int'(flt_valid), 0);
        eq("R7 rest retire", int'(cmt_cnt), 2);
        eq("R7 rest seq", int'(cmt_seq), 62);

        // R2: dropped lane and full buffer
        do_reset();
        lane(0, 200, 1'b0, 1'b0, 1'b1);
        lane(1, 201, 1'b0, 1'b0, 1'b0);
        step(); idle_in();
        eq("R2 drop free", int'(free), 7);
        eq("R2 drop alloc", int'(alloc_ptr), 1);
        fill(7, 202);
        eq("R2 full", int'(free), 0);
        lane(0, 230, 1'b0, 1'b0, 1'b0);
        lane(1, 231, 1'b0, 1'b0, 1'b0);
        step(); idle_in();
        eq("R2 overflow discarded", int'(free), 0);
        eq("R2 overflow alloc", int'(alloc_ptr), 0);
        cpl(0, 0, 1'b0);
        step(); idle_in();
        step();
        eq("R2 slot0 intact", int'(cmt_seq), 201);

        // R12: completion to an empty slot
        do_reset();
        cpl(0, 3, 1'b0);
        step(); idle_in();
        fill(4, 70);
        tot = 0;
        cpl(0, 0, 1'b0); cpl(1, 1, 1'b0);
        step(); idle_in();
        cpl(0, 2, 1'b0);
        step(); idle_in();
        repeat (3) step();
        eq("R12 stale mark ignored", tot, 3);
        eq("R12 free", int'(free), 7);

        // R8-R11: squash walk sweep
        for (int n = 2; n <= DEPTH; n++) begin
            for (int k = 1; k < n; k++) begin
                int w;
                int rem;
                do_reset();
                fill(n, 100);
                sq_valid   = 1'b1;
                sq_seq     = SEQ_W'(100 + k - 1);
                sq_mispred = 1'b1;
                sq_taken   = k[0];
                sq_next_pc = PC_W'(16'h1000 + k);
                sq_bad_pc  = PC_W'(16'h2000 + n);
                lane(0, 250, 1'b0, 1'b0, 1'b0);
                step();
                eq("R8 flag", int'(sq_flag), 1);
                eq("R8 squashing", int'(squashing), 1);
                eq("R8 seq", int'(sq_seq_out), 100 + k - 1);
                eq("R8 fwd", int'({sq_mispred_out, sq_taken_out}), 2 + (k % 2));
                eq("R8 next pc", int'(sq_next_pc_out), 16'h1000 + k);
                eq("R8 bad pc", int'(sq_bad_pc_out), 16'h2000 + n);
                eq("R8 no insert", int'(free), 8 - n);
                w = (n - k + 1) / 2;
                for (int j = 1; j <= w; j++) begin
                    step();
                    rem = n - 2 * j;
                    if (rem < k) rem = k;
                    eq("R9 squashing", int'({sq_flag, squashing}), 1);
                    eq("R9 tail seq", int'(sq_seq_out), 100 + rem - 1);
                    eq("R11 free during walk", int'(free), 8 - rem);
                end
                step();
                eq("R10 walk done", int'(squashing), 0);
                eq("R10 free at done", int'(free), 8 - k);
                idle_in();
                step();
                eq("R11 alloc after walk", int'(alloc_ptr), k);
                eq("R11 free after walk", int'(free), 8 - k);
            end
        end

        summary();
        $finish;
    end

endmodule